// File: doc/BRIEF.md
# Stop-Mode Wake Stabilization Controller

This block sequences the exit from a low-power halt in a small microcontroller core. While the core runs, a one-cycle stop strobe parks it in a halted phase. The halted phase lasts until an interrupt request arrives. The block then holds the core stalled for an oscillation-settling interval before it raises the run enable again. A reset also produces a settling interval. For reset, the length is fixed. For an interrupt wake, the length comes from a three-bit mode register that software writes through a simple write port.

The selectable intervals are power-of-two counts of the main clock: 2^20, 2^17, 2^15 or 2^13. A parameter `SCALE_SHIFT` lowers every exponent by the same amount so that short runs can cover every setting. The interval is latched when the wake occurs. A counter then measures it, cleared on each wake, and run enable rises on the cycle the count reaches its end. A two-bit phase output reports whether the core is running, halted or settling.

Top module: `stop_wait_ctrl`

## Requirements
- R1: Reset (rst_n low, sampled on the clock) clears the mode register to 3'b000, forces phase to settling and holds cpu_run low. cpu_run then rises after exactly 2^(15-SCALE_SHIFT) rising edges with rst_n high, whatever the mode register holds or is written to during that time.
- R2: The phase output encodes 2'b00 running, 2'b01 halted and 2'b10 settling, and is never 2'b11. cpu_run is high exactly when phase is 2'b00.
- R3: A stop_req sampled high while running moves the block to halted at that edge, and cpu_run goes low.
- R4: While halted, the block stays halted until irq_req is sampled high. A stop_req sampled in that phase changes nothing.
- R5: An irq_req sampled high while halted starts settling at that edge. cpu_run rises after exactly 2^(E-SCALE_SHIFT) further edges, where E is 20 for mode 3'b000, 17 for 3'b011, 15 for 3'b101 and 13 for 3'b111.
- R6: Mode values 3'b001, 3'b010, 3'b100 and 3'b110 give the same interval as 3'b000.
- R7: The interval is fixed by the mode value held on the wake edge. A mode write during settling changes only later wakes.
- R8: A stop_req sampled during settling is ignored. Settling always ends in running.
- R9: An irq_req sampled while running or settling has no effect. When stop_req and irq_req are both sampled high while running, the block halts.
- R10: No setup time is needed between the stop and the wake. An irq_req sampled on the first edge after the halt begins already starts settling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset; also starts the fixed settling interval |
| stop_req | input | 1 | One-cycle strobe that halts the running core |
| irq_req | input | 1 | Interrupt request that wakes the halted core |
| mode_we | input | 1 | Mode register write enable |
| mode_wdata | input | 3 | Mode value to write |
| cpu_run | output | 1 | High when the core may execute |
| phase | output | 2 | Current phase: 00 running, 01 halted, 10 settling |

## Verification
A stop or wake strobe changes phase on the first rising edge that samples it. The bench drives the strobe at a falling edge and reads phase at the next falling edge. Run enable is due exactly N edges after the wake edge, or after the first edge with rst_n high. To check this, the bench counts the falling edges on which cpu_run is still low, starting at the first falling edge after that edge, and compares the count with N computed from the mode value held at the wake. While it counts, it injects random stop, interrupt and mode-write noise and keeps track of which mode value applies to the next wake.

// File: rtl/stw_pkg.sv
// Shared types and constants for the stop-mode wake controller.
// Assumes the mode code is three bits wide; unlisted codes map to the longest wait.
package stw_pkg;

    typedef enum logic [1:0] {
        PH_RUN  = 2'b00,
        PH_STOP = 2'b01,
        PH_WAIT = 2'b10
    } phase_e;

    localparam int MODE_W    = 3;
    localparam int EXP_LONG  = 20;
    localparam int EXP_MID   = 17;
    localparam int EXP_SHORT = 15;
    localparam int EXP_MIN   = 13;
    localparam int EXP_RESET = 15;
    localparam int EXP_W     = $clog2(EXP_LONG + 1);

    // Map a mode code to the unscaled power-of-two exponent of its wait.
    function automatic int unsigned code_to_exp(input logic [MODE_W-1:0] code);
        case (code)
            3'b011:  return EXP_MID;
            3'b101:  return EXP_SHORT;
            3'b111:  return EXP_MIN;
            default: return EXP_LONG;
        endcase
    endfunction

endpackage

// File: rtl/stw_mode_reg.sv
// Holds the software-written wait-select code.
// Assumes writes are single-cycle pulses; reset returns the code to zero.
module stw_mode_reg
    import stw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wr_data,
    output logic [MODE_W-1:0] mode_o
);

    logic [MODE_W-1:0] mode_q;

    // Capture a new code on write, clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (wr_en) begin
            mode_q <= wr_data;
        end
    end

    assign mode_o = mode_q;

endmodule

// File: rtl/stw_len_sel.sv
// Latches the wait exponent when a wake starts and supplies the counter's
// terminal value (length minus one). Reset loads the fixed reset exponent.
// Assumes SCALE_SHIFT does not exceed the smallest exponent.
module stw_len_sel
    import stw_pkg::*;
#(
    parameter int SCALE_SHIFT = 0,
    parameter int CNT_W       = EXP_LONG - SCALE_SHIFT + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [MODE_W-1:0] mode_i,
    output logic [CNT_W-1:0]  term_m1
);

    localparam logic [EXP_W-1:0] RST_EXP = EXP_W'(EXP_RESET - SCALE_SHIFT);
    localparam logic [CNT_W-1:0] ONE     = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [EXP_W-1:0] exp_q;

    // Freeze the exponent at the wake edge; reset selects the fixed one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q <= RST_EXP;
        end else if (load) begin
            exp_q <= EXP_W'(code_to_exp(mode_i) - SCALE_SHIFT);
        end
    end

    assign term_m1 = (ONE << exp_q) - ONE;

endmodule

// File: rtl/stw_wait_ctr.sv
// Up-counter that measures the settling interval.
// Assumes clr and en are never useful together; clr has priority.
module stw_wait_ctr #(
    parameter int CNT_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [CNT_W-1:0] term_m1,
    output logic             hit
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    // Clear on reset or wake, otherwise advance while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    assign hit = (cnt_q == term_m1);

endmodule

// File: rtl/stop_wait_ctrl.sv
// Stop-mode wake controller top. It halts the core on a stop strobe, wakes on
// an interrupt, and stalls the core for a settling interval after a wake or a
// reset. Assumes all inputs are synchronous to clk.
module stop_wait_ctrl
    import stw_pkg::*;
#(
    parameter int SCALE_SHIFT = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop_req,
    input  logic       irq_req,
    input  logic       mode_we,
    input  logic [2:0] mode_wdata,
    output logic       cpu_run,
    output logic [1:0] phase
);

    localparam int CNT_W = EXP_LONG - SCALE_SHIFT + 1;

    phase_e            phase_q;
    phase_e            phase_d;
    logic [MODE_W-1:0] mode_q;
    logic [CNT_W-1:0]  term_m1;
    logic              hit;
    logic              wake;
    logic              cnt_en;

    stw_mode_reg u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mode_we),
        .wr_data (mode_wdata),
        .mode_o  (mode_q)
    );

    stw_len_sel #(
        .SCALE_SHIFT (SCALE_SHIFT),
        .CNT_W       (CNT_W)
    ) u_len (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (wake),
        .mode_i  (mode_q),
        .term_m1 (term_m1)
    );

    stw_wait_ctr #(
        .CNT_W (CNT_W)
    ) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (wake),
        .en      (cnt_en),
        .term_m1 (term_m1),
        .hit     (hit)
    );

    assign wake   = (phase_q == PH_STOP) && irq_req;
    assign cnt_en = (phase_q == PH_WAIT) && !hit;

    // Choose the next phase from the current one and the strobes.
    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_RUN:  if (stop_req) phase_d = PH_STOP;
            PH_STOP: if (irq_req)  phase_d = PH_WAIT;
            PH_WAIT: if (hit)      phase_d = PH_RUN;
            default: phase_d = PH_WAIT;
        endcase
    end

    // Phase register; reset begins the fixed settling interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_WAIT;
        end else begin
            phase_q <= phase_d;
        end
    end

    assign cpu_run = (phase_q == PH_RUN);
    assign phase   = phase_q;

endmodule

// File: rtl/stw_checker.sv
// Temporal checks on the wake controller, attached to every instance by bind.
// Tracks the expected settling length on its own and compares it at run start.
module stw_checker
    import stw_pkg::*;
#(
    parameter int SCALE_SHIFT = 0
) (
    input logic       clk,
    input logic       rst_n,
    input logic       stop_req,
    input logic       irq_req,
    input logic [2:0] mode_q,
    input logic       cpu_run,
    input logic [1:0] phase
);

    int seen;
    int exp_len;

    // Count settling cycles and record the length owed by the last release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen    <= 0;
            exp_len <= 1 << (EXP_RESET - SCALE_SHIFT);
        end else if (phase == 2'b01 && irq_req) begin
            seen    <= 0;
            exp_len <= 1 << (int'(code_to_exp(mode_q)) - SCALE_SHIFT);
        end else if (phase == 2'b10) begin
            seen <= seen + 1;
        end
    end

    AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        phase != 2'b11); // R2
    AST_STOP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b00 && stop_req) |=> (phase == 2'b01 && !cpu_run)); // R3
    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b01 && !irq_req) |=> phase == 2'b01); // R4
    AST_IRQ_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b01 && irq_req) |=> (phase == 2'b10 && !cpu_run)); // R10
    AST_WAIT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_run) |-> seen == exp_len); // R5
    AST_WAIT_NO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        phase == 2'b10 |=> phase != 2'b01); // R8
    AST_RUN_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b00 && !stop_req) |=> phase == 2'b00); // R9

endmodule

bind stop_wait_ctrl stw_checker #(.SCALE_SHIFT(SCALE_SHIFT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop_req (stop_req),
    .irq_req  (irq_req),
    .mode_q   (mode_q),
    .cpu_run  (cpu_run),
    .phase    (phase)
);

// File: tb/sim_stop_wait_ctrl.sv
// Bench: random and directed stop/wake sequences with waits shortened by 2^10.
module sim_stop_wait_ctrl;

    localparam int SCALE = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stop_req = 1'b0;
    logic       irq_req = 1'b0;
    logic       mode_we = 1'b0;
    logic [2:0] mode_wdata = 3'b000;
    logic       cpu_run;
    logic [1:0] phase;

    int  vec = 0;
    int  bad = 0;
    bit  done = 1'b0;
    logic [2:0] cur_mode = 3'b000;

    stop_wait_ctrl #(.SCALE_SHIFT(SCALE)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .stop_req   (stop_req),
        .irq_req    (irq_req),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .cpu_run    (cpu_run),
        .phase      (phase)
    );

    // 20-unit period: 50 MHz with a 1 ns unit.
    always #10 clk = ~clk;

    function automatic int exp_wait(input logic [2:0] code);
        case (code)
            3'b011:  return 1 << (17 - SCALE);
            3'b101:  return 1 << (15 - SCALE);
            3'b111:  return 1 << (13 - SCALE);
            default: return 1 << (20 - SCALE);
        endcase
    endfunction

    localparam int RST_WAIT = 1 << (15 - SCALE);

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic write_mode(input logic [2:0] code);
        mode_we = 1'b1;
        mode_wdata = code;
        cur_mode = code;
        tick();
        mode_we = 1'b0;
    endtask

    // Count falling edges with cpu_run low; optional noise on the inputs.
    task automatic measure(input string req, input int expv, input bit noise);
        int n = 0;
        while (!cpu_run && n < 5000) begin
            if (noise) begin
                stop_req = 1'($urandom_range(0, 1));
                irq_req  = 1'($urandom_range(0, 1));
                mode_we  = ($urandom_range(0, 3) == 0);
                mode_wdata = 3'($urandom_range(0, 7));
                if (mode_we) cur_mode = mode_wdata;
            end
            n++;
            tick();
        end
        stop_req = 1'b0;
        irq_req  = 1'b0;
        mode_we  = 1'b0;
        chk(n == expv, req, n, expv);
        chk(phase == 2'b00 && cpu_run, "R2 run phase", int'(phase), 0);
    endtask

    task automatic do_reset(input bit noise);
        rst_n = 1'b0;
        repeat (3) tick();
        chk(phase == 2'b10, "R1 reset phase", int'(phase), 2);
        chk(!cpu_run, "R1 reset run low", int'(cpu_run), 0);
        cur_mode = 3'b000;
        rst_n = 1'b1;
        measure("R1 reset wait", RST_WAIT, noise);
    endtask

    task automatic go_stop();
        stop_req = 1'b1;
        tick();
        stop_req = 1'b0;
        chk(phase == 2'b01 && !cpu_run, "R3 stop entry", int'(phase), 1);
    endtask

    task automatic wake(input string req, input bit noise);
        int expv;
        expv = exp_wait(cur_mode);
        irq_req = 1'b1;
        tick();
        irq_req = 1'b0;
        chk(phase == 2'b10, "R10 wake on first stop cycle", int'(phase), 2);
        measure(req, expv, noise);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        tick();
        // R1: reset wait, mode writes and strobes during it are ignored.
        do_reset(1'b1);
        // R1: reset clears a programmed mode.
        write_mode(3'b111);
        do_reset(1'b0);
        go_stop();
        wake("R1 mode cleared to 000", 1'b0);

        // R5: each listed code.
        foreach (exp_wait_codes[i]) begin
            write_mode(exp_wait_codes[i]);
            go_stop();
            wake("R5 listed code wait", 1'b0);
        end
        // R6: unlisted codes behave as 000.
        foreach (odd_codes[i]) begin
            write_mode(odd_codes[i]);
            go_stop();
            wake("R6 unlisted code wait", 1'b0);
        end

        // R7: a write during settling applies only to the next wake.
        write_mode(3'b111);
        go_stop();
        irq_req = 1'b1;
        tick();
        irq_req = 1'b0;
        write_mode(3'b000);
        measure("R7 latched wait", exp_wait(3'b111) - 1, 1'b0);
        go_stop();
        wake("R7 next wake uses new code", 1'b0);

        // R9: stop and irq together while running: halt wins.
        stop_req = 1'b1;
        irq_req = 1'b1;
        tick();
        stop_req = 1'b0;
        irq_req = 1'b0;
        chk(phase == 2'b01, "R9 stop beats irq", int'(phase), 1);
        wake("R5 wake after joint strobe", 1'b0);

        // Random sequences with noise; R4, R8, R9 exercised throughout.
        for (int it = 0; it < 20; it++) begin
            write_mode(3'($urandom_range(0, 7)));
            for (int k = 0; k < int'($urandom_range(1, 4)); k++) begin
                irq_req = 1'b1;
                tick();
                irq_req = 1'b0;
                chk(phase == 2'b00 && cpu_run, "R9 irq ignored while running", int'(phase), 0);
            end
            go_stop();
            for (int k = 0; k < int'($urandom_range(0, 4)); k++) begin
                stop_req = 1'($urandom_range(0, 1));
                tick();
                stop_req = 1'b0;
                chk(phase == 2'b01 && !cpu_run, "R4 halted holds", int'(phase), 1);
            end
            wake("R8 random wait with noise", 1'b1);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    logic [2:0] exp_wait_codes [4] = '{3'b000, 3'b011, 3'b101, 3'b111};
    logic [2:0] odd_codes      [4] = '{3'b001, 3'b010, 3'b100, 3'b110};

endmodule